// File: doc/BRIEF.md
# Multiplexed Local Bus Burst Master

This block masters a local bus whose address and data share one set of 32 wires. An internal client supplies one request: a start byte address, a direction, a word count and, for writes, a stream of data words. The block turns that request into bus accesses. Each access opens with a single address clock and then runs one or more data clocks. During the access the block drives the address strobe, the address latch enable, the last-word marker, the direction line, the transceiver enable and the receive steering line. A separate two-bit word-select output follows address bits 3:2 of the word in flight.

Each data clock completes only when the slave signals ready, or when it signals burst terminate and that input is enabled. When terminate is disabled, a burst stops at the end of each aligned four-word line. A new address clock then restarts the access at the next word. When terminate is enabled, the burst runs on until the slave terminates it. The master then issues a fresh address clock for the next word that has not been moved. The word counter keeps counting across restarts, so the number of words moved equals the requested count. When the request is finished the bus returns to idle and a one-clock done pulse is raised.

Top module: `lbm_master`

## Requirements
- R1: `req_ready` is high only while no request is in progress. A request is taken on a clock where `req_valid` and `req_ready` are both high. After reset all bus controls are inactive (`ads_n`, `den_n`, `blast_n` high, `ale` low, `bus_ad_oe` low) and `req_ready` is high.
- R2: Every access begins with exactly one address clock. In that clock `ads_n` is low, `ale` is high and `bus_ad_oe` is high. `bus_ad_out` bits 31:2 hold the word address of the next word to move, and bits 1:0 are zero.
- R3: In a data clock `den_n` is low while `ale` is low and `ads_n` is high. A write drives its data word on `bus_ad_out` with `bus_ad_oe` high. A read releases the bus (`bus_ad_oe` low) and drives `xcvr_rx_n` low.
- R4: `wr_n_rd` is high for writes and low for reads throughout the address and data clocks of an access.
- R5: A data clock completes on a rising edge only if `rdy_n` is low, or if `bterm_n` is low and `cfg_term_en` is high. Otherwise the clock repeats as a wait state. `wr_take` (writes) and `rd_valid` with `rd_data` (reads) are high only in the clock that completes.
- R6: `wsel` shows address bits 3:2 of the word in flight and advances by one, modulo 4, after each completed data clock.
- R7: With `cfg_term_en` low, a burst never moves past the last word of an aligned 16-byte line. The word after the line end starts with a new address clock, and `bterm_n` has no effect.
- R8: With `cfg_term_en` high, a burst continues across line boundaries. A data clock completed by `bterm_n` low ends the access, and the next word starts with a new address clock carrying its address. When both `rdy_n` and `bterm_n` are low, terminate wins.
- R9: `blast_n` is low in a data clock exactly when that word is the final word of the request, or when `cfg_term_en` is low and the word is the last of its 16-byte line.
- R10: The total number of completed data clocks equals `req_count`. One clock after the final word, `done` is high for one clock and the bus is idle. A count of zero gives the done pulse with no address clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_term_en | input | 1 | Enables the burst-terminate input |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, able to take a request |
| req_write | input | 1 | 1 = write request, 0 = read |
| req_addr | input | 32 | Start byte address (bits 1:0 ignored) |
| req_count | input | 8 | Number of 32-bit words to move |
| wr_data | input | 32 | Current write word, held until taken |
| wr_take | output | 1 | Current write word consumed this clock |
| rd_data | output | 32 | Read word, valid with rd_valid |
| rd_valid | output | 1 | Read word captured this clock |
| done | output | 1 | One-clock pulse at request end |
| bus_ad_out | output | 32 | Shared address/data bus, outgoing value |
| bus_ad_oe | output | 1 | Drive enable for the shared bus |
| bus_ad_in | input | 32 | Shared address/data bus, incoming value |
| ale | output | 1 | Address latch enable, high in address clock |
| ads_n | output | 1 | Address strobe, active low |
| blast_n | output | 1 | Last word of access marker, active low |
| wr_n_rd | output | 1 | Direction: high write, low read |
| den_n | output | 1 | Data enable, active low in data clocks |
| xcvr_rx_n | output | 1 | Transceiver receive steering, active low |
| wsel | output | 2 | Word select, address bits 3:2 |
| rdy_n | input | 1 | Slave ready, active low |
| bterm_n | input | 1 | Burst terminate, active low |

## Verification
Aligned four-word writes and reads with no waits give the baseline of one address clock per line. Unaligned six-word requests with terminate disabled and then enabled separate the restart at the line end from a burst that runs straight through. Added wait states show that only ready or an enabled terminate ends a data clock. A terminate in mid-burst must restart at the next word address. A terminate while disabled must stall with no data taken. A single-word request and a zero-word request cover the last-word marker on the first data clock and the done pulse with no bus activity.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_FIN  = 2'd3
    } lbm_state_e;

    typedef struct packed {
        logic ale;
        logic ads_n;
        logic blast_n;
        logic den_n;
        logic rx_n;
        logic dir_wr;
        logic ad_oe;
    } lbm_ctl_t;

    function automatic lbm_ctl_t ctl_quiet();
        lbm_ctl_t c;
        c.ale     = 1'b0;
        c.ads_n   = 1'b1;
        c.blast_n = 1'b1;
        c.den_n   = 1'b1;
        c.rx_n    = 1'b1;
        c.dir_wr  = 1'b0;
        c.ad_oe   = 1'b0;
        return c;
    endfunction

    function automatic logic burst_stop(input logic last_word, input logic line_end,
                                        input logic term_en);
        return last_word || (!term_en && line_end);
    endfunction

endpackage

// File: rtl/lbm_addr_gen.sv
module lbm_addr_gen #(
    parameter int WA_W  = 30,
    parameter int CNT_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WA_W-1:0]  ld_waddr,
    input  logic [CNT_W-1:0] ld_count,
    input  logic             step,
    output logic [WA_W-1:0]  waddr,
    output logic [CNT_W-1:0] left,
    output logic             last_word,
    output logic             line_end
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            waddr <= '0;
            left  <= '0;
        end else if (load) begin
            waddr <= ld_waddr;
            left  <= ld_count;
        end else if (step) begin
            waddr <= waddr + WA_W'(1);
            left  <= left - ONE;
        end
    end

    assign last_word = (left == ONE);
    assign line_end  = &waddr[SEL_W-1:0];
endmodule

// File: rtl/lbm_fsm.sv
module lbm_fsm
    import lbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_fire,
    input  logic       req_zero,
    input  logic       beat_done,
    input  logic       term_hit,
    input  logic       last_word,
    input  logic       line_end,
    input  logic       term_en,
    output lbm_state_e state
);
    lbm_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_fire) nxt = req_zero ? ST_FIN : ST_ADDR;
            ST_ADDR: nxt = ST_DATA;
            ST_DATA: begin
                if (beat_done) begin
                    if (last_word)
                        nxt = ST_FIN;
                    else if (term_hit || burst_stop(1'b0, line_end, term_en))
                        nxt = ST_ADDR;
                end
            end
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/lbm_pin_map.sv
module lbm_pin_map
    import lbm_pkg::*;
#(
    parameter int DW    = 32,
    parameter int WA_W  = 30,
    parameter int SEL_W = 2
) (
    input  lbm_state_e       state,
    input  logic             is_write,
    input  logic             last_word,
    input  logic             line_end,
    input  logic             term_en,
    input  logic [WA_W-1:0]  waddr,
    input  logic [DW-1:0]    wr_data,
    output lbm_ctl_t         ctl,
    output logic [DW-1:0]    ad_out,
    output logic [SEL_W-1:0] wsel
);
    localparam int LOW_W = DW - WA_W;

    always_comb begin
        ctl    = ctl_quiet();
        ad_out = '0;
        wsel   = '0;
        unique case (state)
            ST_ADDR: begin
                ctl.ale    = 1'b1;
                ctl.ads_n  = 1'b0;
                ctl.ad_oe  = 1'b1;
                ctl.dir_wr = is_write;
                ad_out     = {waddr, {LOW_W{1'b0}}};
                wsel       = waddr[SEL_W-1:0];
            end
            ST_DATA: begin
                ctl.den_n   = 1'b0;
                ctl.dir_wr  = is_write;
                ctl.ad_oe   = is_write;
                ctl.rx_n    = is_write;
                ctl.blast_n = !burst_stop(last_word, line_end, term_en);
                ad_out      = is_write ? wr_data : '0;
                wsel        = waddr[SEL_W-1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lbm_master.sv
module lbm_master
    import lbm_pkg::*;
#(
    parameter int DW         = 32,
    parameter int CNT_W      = 8,
    parameter int LINE_WORDS = 4,
    localparam int SEL_W     = $clog2(LINE_WORDS),
    localparam int WA_W      = DW - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_term_en,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [DW-1:0]    req_addr,
    input  logic [CNT_W-1:0] req_count,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_take,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic [DW-1:0]    bus_ad_out,
    output logic             bus_ad_oe,
    input  logic [DW-1:0]    bus_ad_in,
    output logic             ale,
    output logic             ads_n,
    output logic             blast_n,
    output logic             wr_n_rd,
    output logic             den_n,
    output logic             xcvr_rx_n,
    output logic [SEL_W-1:0] wsel,
    input  logic             rdy_n,
    input  logic             bterm_n
);
    lbm_state_e       state;
    lbm_ctl_t         ctl;
    logic             wr_q;
    logic             req_fire;
    logic             beat_done;
    logic             term_hit;
    logic [WA_W-1:0]  waddr;
    logic [CNT_W-1:0] left;
    logic             last_word;
    logic             line_end;
    logic [1:0]       unused_addr_lo;

    assign unused_addr_lo = req_addr[1:0];
    assign req_ready = (state == ST_IDLE);
    assign req_fire  = req_valid && req_ready;
    assign term_hit  = cfg_term_en && !bterm_n;
    assign beat_done = (state == ST_DATA) && (!rdy_n || term_hit);

    always_ff @(posedge clk) begin
        if (rst)           wr_q <= 1'b0;
        else if (req_fire) wr_q <= req_write;
    end

    lbm_addr_gen #(.WA_W(WA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (req_fire),
        .ld_waddr  (req_addr[DW-1:2]),
        .ld_count  (req_count),
        .step      (beat_done),
        .waddr     (waddr),
        .left      (left),
        .last_word (last_word),
        .line_end  (line_end)
    );

    lbm_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_fire  (req_fire),
        .req_zero  (req_count == '0),
        .beat_done (beat_done),
        .term_hit  (term_hit),
        .last_word (last_word),
        .line_end  (line_end),
        .term_en   (cfg_term_en),
        .state     (state)
    );

    lbm_pin_map #(.DW(DW), .WA_W(WA_W), .SEL_W(SEL_W)) u_pins (
        .state     (state),
        .is_write  (wr_q),
        .last_word (last_word),
        .line_end  (line_end),
        .term_en   (cfg_term_en),
        .waddr     (waddr),
        .wr_data   (wr_data),
        .ctl       (ctl),
        .ad_out    (bus_ad_out),
        .wsel      (wsel)
    );

    assign ale       = ctl.ale;
    assign ads_n     = ctl.ads_n;
    assign blast_n   = ctl.blast_n;
    assign den_n     = ctl.den_n;
    assign xcvr_rx_n = ctl.rx_n;
    assign wr_n_rd   = ctl.dir_wr;
    assign bus_ad_oe = ctl.ad_oe;

    assign wr_take  = beat_done && wr_q;
    assign rd_valid = beat_done && !wr_q;
    assign rd_data  = bus_ad_in;
    assign done     = (state == ST_FIN);
endmodule

// File: rtl/lbm_master_chk.sv
module lbm_master_chk #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_term_en,
    input logic             req_ready,
    input logic             ale,
    input logic             ads_n,
    input logic             blast_n,
    input logic             den_n,
    input logic             done,
    input logic [SEL_W-1:0] wsel,
    input logic             rdy_n,
    input logic             bterm_n
);
    // R1: no request taken while an access runs
    a_r1_busy_in_addr: assert property (@(posedge clk) disable iff (rst)
        !ads_n |-> !req_ready);

    // R2: address strobe lasts one clock
    a_r2_ads_single: assert property (@(posedge clk) disable iff (rst)
        !ads_n |=> ads_n);

    // R3: a data clock always follows the address clock
    a_r3_data_follows: assert property (@(posedge clk) disable iff (rst)
        !ads_n |=> (!den_n && !ale));

    // R5: without ready or enabled terminate the data clock holds
    a_r5_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (!den_n && rdy_n && (bterm_n || !cfg_term_en)) |=> (!den_n && $stable(wsel)));

    // R6: word select advances after a non-final completed word
    a_r6_wsel_step: assert property (@(posedge clk) disable iff (rst)
        (!den_n && !rdy_n && blast_n) |=> (wsel == $past(wsel) + SEL_W'(1)));

    // R9: data clocks stop after a marked last word completes
    a_r9_blast_ends: assert property (@(posedge clk) disable iff (rst)
        (!den_n && !blast_n && !rdy_n) |=> den_n);

    // R10: done lasts one clock and leaves the master idle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));
endmodule

bind lbm_master lbm_master_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_lbm_master.sv
`timescale 1ns/1ps
module tb_lbm_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_term_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_count = '0;
    logic [31:0] wr_data = '0;
    logic        wr_take;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        done;
    logic [31:0] bus_ad_out;
    logic        bus_ad_oe;
    logic [31:0] bus_ad_in = '0;
    logic        ale, ads_n, blast_n, wr_n_rd, den_n, xcvr_rx_n;
    logic [1:0]  wsel;
    logic        rdy_n = 1'b1;
    logic        bterm_n = 1'b1;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    logic [31:0] mem [64];

    always #2.5 clk = ~clk;

    lbm_master dut (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] wpat(input int k);
        return 32'hC0DE_0000 ^ (32'(k) * 32'h0101_0011);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(ads_n && den_n && blast_n && !ale && !bus_ad_oe && req_ready && !done,
            tag, {ads_n, den_n, blast_n, ale, bus_ad_oe, req_ready, done}, 7'b1110010);
    endtask

    // One request; a slave model answers with fixed waits and an optional terminate.
    task automatic xfer(input bit wr, input logic [31:0] a, input int n, input bit ten,
                        input int waits, input int tbeat, input string name);
        int beats = 0, aph = 0, wcnt = 0, cyc = 0, exp_aph = 0;
        int pin_bad = 0, wait_bad = 0, ign_bad = 0, data_bad = 0;
        bit tried = 0, saw_done = 0, expb;
        logic [29:0] cur = '0;
        logic [29:0] ew;
        exp_aph = (n > 0) ? 1 : 0;
        for (int b = 0; b < n - 1; b++) begin
            ew = a[31:2] + 30'(b);
            if (ten && b == tbeat) exp_aph++;
            else if (!ten && ew[1:0] == 2'b11) exp_aph++;
        end
        @(negedge clk);
        cfg_term_en = ten; req_valid = 1'b1; req_write = wr; req_addr = a;
        req_count = 8'(n); wr_data = wpat(0);
        @(negedge clk);
        req_valid = 1'b0;
        while (!saw_done && cyc < 400) begin
            cyc++;
            rdy_n = 1'b1; bterm_n = 1'b1; wr_data = wpat(beats);
            if (done) begin
                saw_done = 1;
            end else if (!ads_n) begin
                aph++;
                ew = a[31:2] + 30'(beats);
                // R1 R2 R4 address clock
                if (!(ale && bus_ad_oe && den_n && bus_ad_out[1:0] == 2'b00 &&
                      bus_ad_out[31:2] == ew && wr_n_rd == wr && !req_ready))
                    pin_bad++;
                cur = bus_ad_out[31:2];
            end else if (!den_n) begin
                expb = (beats == n - 1) || (!ten && cur[1:0] == 2'b11);
                // R3 R4 R6 R9 data clock
                if (ale || !ads_n || wsel != cur[1:0] || blast_n == expb ||
                    bus_ad_oe != wr || xcvr_rx_n != wr || wr_n_rd != wr)
                    pin_bad++;
                if (!wr) bus_ad_in = mem[cur[5:0]];
                if (wcnt < waits) begin
                    wcnt++;
                    #1 if (wr_take || rd_valid) wait_bad++;
                end else if (beats == tbeat && !tried && !ten) begin
                    tried = 1; bterm_n = 1'b0;
                    #1 if (wr_take || rd_valid) ign_bad++;
                end else begin
                    if (beats == tbeat && !tried) begin
                        tried = 1; bterm_n = 1'b0;
                    end else begin
                        rdy_n = 1'b0;
                    end
                    #1;
                    if (wr) begin
                        if (!wr_take || rd_valid || bus_ad_out != wpat(beats)) data_bad++;
                        mem[cur[5:0]] = bus_ad_out;
                    end else begin
                        if (!rd_valid || wr_take || rd_data != mem[cur[5:0]]) data_bad++;
                    end
                    beats++; cur = cur + 30'd1; wcnt = 0;
                end
            end else begin
                pin_bad++;
            end
            @(negedge clk);
        end
        rdy_n = 1'b1; bterm_n = 1'b1;
        chk(saw_done, {name, " R10 done pulse seen"}, 32'(saw_done), 1);
        chk(beats == n, {name, " R10 word count"}, 32'(beats), 32'(n));
        chk(aph == exp_aph, {name, " R7 R8 address clocks"}, 32'(aph), 32'(exp_aph));
        chk(pin_bad == 0, {name, " R2 R3 R4 R6 R9 pin values"}, 32'(pin_bad), 0);
        chk(wait_bad == 0, {name, " R5 wait clocks move nothing"}, 32'(wait_bad), 0);
        chk(ign_bad == 0, {name, " R7 disabled terminate ignored"}, 32'(ign_bad), 0);
        chk(data_bad == 0, {name, " R3 R5 data words"}, 32'(data_bad), 0);
        @(negedge clk);
        check_idle({name, " R10 idle after done"});
    endtask

    task automatic t_reset();
        for (int i = 0; i < 64; i++) mem[i] = 32'h5A00_0000 + 32'(i * 7);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 reset state");
    endtask

    task automatic t_aligned_write();
        xfer(1'b1, 32'h0000_0100, 4, 1'b0, 0, -1, "aligned write");
    endtask

    task automatic t_read_back_waits();
        xfer(1'b0, 32'h0000_0100, 4, 1'b0, 2, -1, "read back with waits");
        chk(mem[0] == wpat(0) && mem[3] == wpat(3), "R3 write then read data",
            mem[3], wpat(3));
    endtask

    task automatic t_unaligned_no_term();
        xfer(1'b1, 32'h0000_0088, 6, 1'b0, 0, -1, "unaligned line split");
    endtask

    task automatic t_unaligned_term_en();
        xfer(1'b0, 32'h0000_0088, 6, 1'b1, 1, -1, "term enabled straight burst");
    endtask

    task automatic t_term_mid();
        xfer(1'b0, 32'h0000_0040, 5, 1'b1, 0, 2, "terminate mid burst");
    endtask

    task automatic t_term_disabled();
        xfer(1'b1, 32'h0000_00C4, 3, 1'b0, 0, 1, "terminate disabled");
    endtask

    task automatic t_single();
        xfer(1'b0, 32'h0000_00C8, 1, 1'b1, 3, -1, "single word");
    endtask

    task automatic t_zero();
        xfer(1'b1, 32'h0000_0000, 0, 1'b0, 0, -1, "zero count");
    endtask

    initial begin
        t_reset();
        t_aligned_write();
        t_read_back_waits();
        t_unaligned_no_term();
        t_unaligned_term_en();
        t_term_mid();
        t_term_disabled();
        t_single();
        t_zero();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule